// File: doc/BRIEF.md
# Converter Bus Interface Controller

This block sits between a processor bus and a parallel-output conversion core. It turns chip-select, read and write strobes into a one-cycle start request for the core. It keeps the end-of-conversion interrupt and the ready/acknowledge line up to date, and it decides when the 8-bit result may be driven onto the shared data bus. A static mode input picks one of two start protocols. In the read-started protocol, asserting the read strobe begins a conversion. In the write-started protocol, the trailing edge of a write strobe begins one and a later read collects the word.

The read-started protocol has a pipelined variant, chosen by a second static input. In this variant every read both launches a new conversion and returns the word of the one before it. Reads that cannot yet hold a real result are marked by a valid flag that travels with the data. Every strobe is taken as already synchronous to `clk`. All strobes are active low.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, `int_n_o` and `rdy_n_o` are high, `db_oe_o` and `db_valid_o` are low, and no start pulse is issued.
- R2: With `mode_wrrd_i`=0, the cycle in which `cs_n_i` and `rd_n_i` first become both low produces exactly one `conv_start_o` pulse. Holding them low, or strobing again while a conversion is running, produces no further pulse.
- R3: With `mode_wrrd_i`=0 and `pipe_rd_i`=0, `db_oe_o` and `db_valid_o` stay low until the conversion has completed. After that, while the strobes are still low, both are high and `db_o` equals the word the core delivered with `conv_done_i`.
- R4: `int_n_o` goes low the cycle after `conv_done_i` ends a running conversion. It returns high with the start pulse of the next accepted conversion.
- R5: `rdy_n_o` goes low the cycle after `cs_n_i` falls. It goes high the cycle after the running conversion completes.
- R6: With `mode_wrrd_i`=1, a conversion starts only on a rising edge of `wr_n_i` while `cs_n_i` is low. A falling read strobe starts nothing.
- R7: With `mode_wrrd_i`=1, a read begun while a conversion is running forces `int_n_o` low at once. `db_oe_o` then goes high, `db_o` carries the core's live output word, and `db_valid_o` stays low until the conversion completes.
- R8: With `mode_wrrd_i`=1 and `cs_n_i` and `rd_n_i` held low throughout, each `wr_n_i` rising edge starts a conversion. `db_o` shows the new word with `db_valid_o` high once it completes.
- R9: With `mode_wrrd_i`=0 and `pipe_rd_i`=1, each read strobe starts a conversion and immediately enables the data bus. `db_o` holds the result of the previous conversion.
- R10: In the pipelined variant, the first and second reads after reset present `db_valid_o` low. From the third read on, it is high.
- R11: A start requested fewer than `GAP_CYC` cycles after a rising edge of `cs_n_i` is ignored.
- R12: `db_oe_o` is high only while `cs_n_i` and `rd_n_i` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wrrd_i | input | 1 | Static protocol select: 0 read-started, 1 write-started |
| pipe_rd_i | input | 1 | Static: selects pipelined reads in the read-started protocol |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| conv_done_i | input | 1 | Conversion-complete pulse from the core |
| conv_data_i | input | DW | Output word of the core |
| conv_start_o | output | 1 | One-cycle start request to the core |
| int_n_o | output | 1 | End-of-conversion interrupt, active low |
| rdy_n_o | output | 1 | Busy / transfer acknowledge, low while busy |
| db_oe_o | output | 1 | Data bus output enable |
| db_o | output | DW | Data bus word |
| db_valid_o | output | 1 | Marks the presented word as a real result |

## Verification
The hardest case to reach from the ports is a read that overlaps a running write-started conversion. The read strobe has to fall inside the window of a few cycles between the start pulse and the core's completion. The bench releases the write strobe and then asserts the read a fixed three cycles later, well inside its core model's latency. The pipelined valid sequence is tied to reset, so that scenario first reapplies reset and then counts three read pulses. The spacing guard is reached by asserting a new read one cycle after raising chip select.

// File: rtl/adc_bus_pkg.sv
// Shared types for the converter bus interface controller.
// Assumes nothing beyond being compiled before the modules that import it.
package adc_bus_pkg;

    // Which start/read protocol is active, decoded from the two static inputs.
    typedef enum logic [1:0] {
        PROT_READ = 2'd0,
        PROT_PIPE = 2'd1,
        PROT_WRRD = 2'd2
    } prot_e;

    // One-cycle events derived from the bus strobes.
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic rd_go;
        logic wr_go;
    } strobe_t;

endpackage

// File: rtl/adc_bus_strobe.sv
// Bus strobe event extraction.
// Registers the previous level of chip select, the combined read strobe and
// the write strobe, then derives single-cycle events from the live levels.
// Assumes all inputs are already synchronous to clk; idle level is high.
module adc_bus_strobe
    import adc_bus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_n_i,
    input  logic    rd_n_i,
    input  logic    wr_n_i,
    output strobe_t strobe_o,
    output logic    rd_act_o,
    output logic    rd_held_o
);

    localparam int NLINE  = 3;
    localparam int IX_CS  = 0;
    localparam int IX_RDA = 1;
    localparam int IX_WR  = 2;

    logic [NLINE-1:0] line_now;
    logic [NLINE-1:0] line_prev;

    assign line_now[IX_CS]  = cs_n_i;
    assign line_now[IX_RDA] = cs_n_i | rd_n_i;
    assign line_now[IX_WR]  = wr_n_i;

    // One history flop per strobe line, reset to the idle (high) level.
    for (genvar g = 0; g < NLINE; g++) begin : g_hist
        always_ff @(posedge clk) begin
            if (!rst_n) line_prev[g] <= 1'b1;
            else        line_prev[g] <= line_now[g];
        end
    end

    // Event decode from previous and current levels.
    always_comb begin
        strobe_o.cs_fall = line_prev[IX_CS] & ~line_now[IX_CS];
        strobe_o.cs_rise = ~line_prev[IX_CS] & line_now[IX_CS];
        strobe_o.rd_go   = line_prev[IX_RDA] & ~line_now[IX_RDA];
        strobe_o.wr_go   = ~line_prev[IX_WR] & line_now[IX_WR] & ~cs_n_i;
    end

    assign rd_act_o  = ~line_now[IX_RDA];
    assign rd_held_o = ~line_now[IX_RDA] & ~line_prev[IX_RDA];

endmodule

// File: rtl/adc_bus_gap.sv
// Inter-conversion spacing timer.
// Loads GAP_CYC when chip select rises and counts down to zero; starts are
// only permitted while the count is zero. Assumes GAP_CYC >= 1.
module adc_bus_gap #(
    parameter int GAP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic ready_o
);

    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Reload on arm, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (arm_i)            cnt_q <= CW'(GAP_CYC);
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign ready_o = (cnt_q == '0);

endmodule

// File: rtl/adc_bus_seq.sv
// Conversion sequencer and handshake state.
// Decides when a start is accepted, tracks the running conversion, captures
// the result, and drives the interrupt, ready and pipelined-valid state.
// Assumes conv_done_i is a single-cycle pulse that only matters while busy.
module adc_bus_seq
    import adc_bus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  prot_e         prot_i,
    input  strobe_t       strobe_i,
    input  logic          gap_ready_i,
    input  logic          conv_done_i,
    input  logic [DW-1:0] conv_data_i,
    output logic          conv_start_o,
    output logic          busy_o,
    output logic          int_n_o,
    output logic          rdy_n_o,
    output logic [DW-1:0] result_o,
    output logic          has_result_o,
    output logic          fresh_o,
    output logic          pipe_valid_o
);

    localparam int PIPE_SKIP = 2;
    localparam int PCW       = $clog2(PIPE_SKIP + 1);

    logic           start_req;
    logic           start_ok;
    logic           finish;
    logic [PCW-1:0] pipe_cnt_q;

    // Start request source depends on the protocol in use.
    always_comb begin
        start_req = (prot_i == PROT_WRRD) ? strobe_i.wr_go : strobe_i.rd_go;
        start_ok  = start_req & ~busy_o & gap_ready_i;
        finish    = busy_o & conv_done_i;
    end

    // Start pulse and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start_o <= 1'b0;
            busy_o       <= 1'b0;
        end else begin
            conv_start_o <= start_ok;
            if (start_ok)    busy_o <= 1'b1;
            else if (finish) busy_o <= 1'b0;
        end
    end

    // Result capture and freshness flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o     <= '0;
            has_result_o <= 1'b0;
            fresh_o      <= 1'b0;
        end else begin
            if (finish) begin
                result_o     <= conv_data_i;
                has_result_o <= 1'b1;
            end
            if (start_ok)    fresh_o <= 1'b0;
            else if (finish) fresh_o <= 1'b1;
        end
    end

    // Interrupt: raised by a new start, dropped at completion or by an early read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   int_n_o <= 1'b1;
        else if (start_ok)                            int_n_o <= 1'b1;
        else if (finish)                              int_n_o <= 1'b0;
        else if (prot_i == PROT_WRRD && strobe_i.rd_go && busy_o)
                                                      int_n_o <= 1'b0;
    end

    // Ready: low after chip select falls, high when the conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                rdy_n_o <= 1'b1;
        else if (strobe_i.cs_fall)                 rdy_n_o <= 1'b0;
        else if (finish)                           rdy_n_o <= 1'b1;
        else if (strobe_i.cs_rise && !busy_o)      rdy_n_o <= 1'b1;
    end

    // Pipelined reads: the first PIPE_SKIP reads after reset are flagged invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_cnt_q   <= '0;
            pipe_valid_o <= 1'b0;
        end else if (prot_i == PROT_PIPE && strobe_i.rd_go) begin
            pipe_valid_o <= (pipe_cnt_q == PCW'(PIPE_SKIP));
            if (pipe_cnt_q != PCW'(PIPE_SKIP)) pipe_cnt_q <= pipe_cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_bus_ctrl.sv
// Converter bus interface controller, top level.
// Decodes the protocol from the static mode inputs, joins the strobe
// decoder, spacing timer and sequencer, and forms the data bus outputs.
// Assumes mode_wrrd_i and pipe_rd_i change only while the bus is idle.
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int DW      = 8,
    parameter int GAP_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wrrd_i,
    input  logic          pipe_rd_i,
    input  logic          cs_n_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    input  logic          conv_done_i,
    input  logic [DW-1:0] conv_data_i,
    output logic          conv_start_o,
    output logic          int_n_o,
    output logic          rdy_n_o,
    output logic          db_oe_o,
    output logic [DW-1:0] db_o,
    output logic          db_valid_o
);

    prot_e         prot;
    strobe_t       strobe;
    logic          rd_act;
    logic          rd_held;
    logic          gap_ready;
    logic          conv_busy;
    logic [DW-1:0] result;
    logic          has_result;
    logic          fresh;
    logic          pipe_valid;

    // Protocol decode from the two static selects.
    always_comb begin
        if (mode_wrrd_i)    prot = PROT_WRRD;
        else if (pipe_rd_i) prot = PROT_PIPE;
        else                prot = PROT_READ;
    end

    adc_bus_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n_i),
        .rd_n_i    (rd_n_i),
        .wr_n_i    (wr_n_i),
        .strobe_o  (strobe),
        .rd_act_o  (rd_act),
        .rd_held_o (rd_held)
    );

    adc_bus_gap #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (strobe.cs_rise),
        .ready_o (gap_ready)
    );

    adc_bus_seq #(.DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .prot_i       (prot),
        .strobe_i     (strobe),
        .gap_ready_i  (gap_ready),
        .conv_done_i  (conv_done_i),
        .conv_data_i  (conv_data_i),
        .conv_start_o (conv_start_o),
        .busy_o       (conv_busy),
        .int_n_o      (int_n_o),
        .rdy_n_o      (rdy_n_o),
        .result_o     (result),
        .has_result_o (has_result),
        .fresh_o      (fresh),
        .pipe_valid_o (pipe_valid)
    );

    // Data bus enable, word and valid flag per protocol.
    always_comb begin
        db_o = result;
        case (prot)
            PROT_PIPE: begin
                db_oe_o    = rd_act;
                db_valid_o = rd_held & pipe_valid;
            end
            PROT_WRRD: begin
                db_oe_o    = rd_act;
                db_valid_o = rd_act & ~conv_busy & has_result;
                if (conv_busy) db_o = conv_data_i;
            end
            default: begin
                db_oe_o    = rd_held & fresh;
                db_valid_o = rd_held & fresh;
            end
        endcase
    end

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
// Protocol checker for adc_bus_ctrl, attached by bind.
// Assumes chip select is high while reset is applied.
module adc_bus_ctrl_chk #(
    parameter int GAP_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic rd_n_i,
    input logic conv_start_o,
    input logic conv_done_i,
    input logic conv_busy,
    input logic int_n_o,
    input logic rdy_n_o,
    input logic db_oe_o,
    input logic db_valid_o
);

    localparam int CW = $clog2(GAP_CYC + 1);

    logic          cs_n_q;
    logic [CW-1:0] gap_q;

    // Independent spacing window since the last chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            gap_q  <= '0;
        end else begin
            cs_n_q <= cs_n_i;
            if (!cs_n_q && cs_n_i) gap_q <= CW'(GAP_CYC);
            else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
        end
    end

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    p_oe_needs_strobes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe_o |-> (!cs_n_i && !rd_n_i));

    p_valid_with_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid_o |-> db_oe_o);

    p_int_high_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> int_n_o);

    p_int_low_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && conv_done_i) |=> !int_n_o);

    p_rdy_low_after_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && cs_n_q) |=> !rdy_n_o);

    p_gap_respected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> ($past(gap_q) == '0));

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n_i),
    .rd_n_i       (rd_n_i),
    .conv_start_o (conv_start_o),
    .conv_done_i  (conv_done_i),
    .conv_busy    (conv_busy),
    .int_n_o      (int_n_o),
    .rdy_n_o      (rdy_n_o),
    .db_oe_o      (db_oe_o),
    .db_valid_o   (db_valid_o)
);

// File: tb/adc_bus_ctrl_bench.sv
// Directed bench for adc_bus_ctrl with a latency-based conversion core model.
module adc_bus_ctrl_bench;

    localparam int DW   = 8;
    localparam int CONV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wrrd = 1'b0;
    logic          pipe_rd = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          conv_done;
    logic [DW-1:0] conv_data;
    logic          conv_start;
    logic          int_n;
    logic          rdy_n;
    logic          db_oe;
    logic [DW-1:0] db;
    logic          db_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int starts  = 0;

    logic [3:0]    core_cnt;
    logic [DW-1:0] core_res;
    logic [DW-1:0] core_seq;

    always #10 clk = ~clk;

    adc_bus_ctrl u_adc_bus_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wrrd_i  (mode_wrrd),
        .pipe_rd_i    (pipe_rd),
        .cs_n_i       (cs_n),
        .rd_n_i       (rd_n),
        .wr_n_i       (wr_n),
        .conv_done_i  (conv_done),
        .conv_data_i  (conv_data),
        .conv_start_o (conv_start),
        .int_n_o      (int_n),
        .rdy_n_o      (rdy_n),
        .db_oe_o      (db_oe),
        .db_o         (db),
        .db_valid_o   (db_valid)
    );

    // Core model: fixed latency, word 8'hEE while converting.
    always @(posedge clk) begin
        if (!rst_n) begin
            core_cnt <= '0;
            core_res <= 8'h00;
            core_seq <= 8'h21;
        end else if (conv_start) begin
            core_cnt <= 4'(CONV);
            core_res <= core_seq;
            core_seq <= core_seq + 8'h11;
        end else if (core_cnt != '0) begin
            core_cnt <= core_cnt - 1'b1;
        end
    end
    assign conv_done = (core_cnt == 4'd1);
    assign conv_data = (core_cnt > 4'd1) ? 8'hEE : core_res;

    always @(posedge clk) if (rst_n && conv_start) starts <= starts + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic bus_idle();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        tick(12);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1", "int_n", int_n, 1);
        check("R1", "rdy_n", rdy_n, 1);
        check("R1", "oe", db_oe, 0);
        check("R1", "valid", db_valid, 0);
        check("R1", "starts", starts, 0);
    endtask

    task automatic t_read_mode();
        int s0;
        mode_wrrd = 1'b0; pipe_rd = 1'b0;
        s0 = starts;
        cs_n = 1'b0;
        tick(2);
        check("R5", "rdy_n after cs fall", rdy_n, 0);
        check("R12", "oe with rd high", db_oe, 0);
        rd_n = 1'b0;
        tick(3);
        check("R3", "oe during conversion", db_oe, 0);
        check("R4", "int_n during conversion", int_n, 1);
        tick(17);
        check("R2", "one start while held", starts - s0, 1);
        check("R3", "oe after done", db_oe, 1);
        check("R3", "valid after done", db_valid, 1);
        check("R3", "data", db, core_res);
        check("R4", "int_n after done", int_n, 0);
        check("R5", "rdy_n after done", rdy_n, 1);
        bus_idle();
        cs_n = 1'b0; rd_n = 1'b0;
        tick(3);
        check("R4", "int_n back high on new start", int_n, 1);
        tick(17);
        check("R2", "second read started once", starts - s0, 2);
        check("R3", "second data", db, core_res);
    endtask

    task automatic t_gap();
        int s0;
        mode_wrrd = 1'b0; pipe_rd = 1'b0;
        cs_n = 1'b1; rd_n = 1'b1;
        tick(1);
        s0 = starts;
        cs_n = 1'b0; rd_n = 1'b0;
        tick(20);
        check("R11", "start inside gap ignored", starts - s0, 0);
        bus_idle();
        cs_n = 1'b0; rd_n = 1'b0;
        tick(20);
        check("R11", "start after gap accepted", starts - s0, 1);
        bus_idle();
    endtask

    task automatic t_write_mode();
        int s0;
        mode_wrrd = 1'b1; pipe_rd = 1'b0;
        s0 = starts;
        cs_n = 1'b0;
        tick(1);
        rd_n = 1'b0;
        tick(15);
        check("R6", "read edge starts nothing", starts - s0, 0);
        rd_n = 1'b1;
        tick(1);
        wr_n = 1'b0;
        tick(3);
        check("R6", "no start while wr low", starts - s0, 0);
        wr_n = 1'b1;
        tick(20);
        check("R6", "start on wr rise", starts - s0, 1);
        check("R4", "int_n after done", int_n, 0);
        rd_n = 1'b0;
        tick(1);
        check("R6", "oe on read", db_oe, 1);
        check("R6", "data on read", db, core_res);
        check("R6", "valid on read", db_valid, 1);
        bus_idle();
    endtask

    task automatic t_early_read();
        mode_wrrd = 1'b1; pipe_rd = 1'b0;
        cs_n = 1'b0;
        tick(1);
        wr_n = 1'b0;
        tick(2);
        wr_n = 1'b1;
        tick(3);
        check("R7", "int_n high before read", int_n, 1);
        rd_n = 1'b0;
        tick(2);
        check("R7", "int_n forced low", int_n, 0);
        check("R7", "oe", db_oe, 1);
        check("R7", "live core word", db, 8'hEE);
        check("R7", "valid low while running", db_valid, 0);
        tick(15);
        check("R7", "valid after done", db_valid, 1);
        check("R7", "data after done", db, core_res);
        bus_idle();
    endtask

    task automatic t_reduced();
        int s0;
        mode_wrrd = 1'b1; pipe_rd = 1'b0;
        s0 = starts;
        cs_n = 1'b0; rd_n = 1'b0;
        tick(2);
        for (int k = 0; k < 2; k++) begin
            wr_n = 1'b0;
            tick(2);
            wr_n = 1'b1;
            tick(3);
            check("R8", "valid low while running", db_valid, 0);
            tick(17);
            check("R8", "valid after done", db_valid, 1);
            check("R8", "data after done", db, core_res);
        end
        check("R8", "starts from wr only", starts - s0, 2);
        bus_idle();
    endtask

    task automatic t_pipe();
        int s0;
        logic [DW-1:0] prev;
        do_reset();
        mode_wrrd = 1'b0; pipe_rd = 1'b1;
        s0 = starts;
        prev = core_res;
        for (int k = 1; k <= 3; k++) begin
            cs_n = 1'b0; rd_n = 1'b0;
            tick(2);
            check("R9", "oe at once", db_oe, 1);
            if (k > 1) check("R9", "previous result", db, prev);
            check("R10", "valid by read index", db_valid, (k == 3) ? 1 : 0);
            cs_n = 1'b1; rd_n = 1'b1;
            tick(20);
            check("R9", "one start per read", starts - s0, k);
            prev = core_res;
        end
        pipe_rd = 1'b0;
        bus_idle();
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_read_mode();
        t_gap();
        t_write_mode();
        t_early_read();
        t_reduced();
        t_pipe();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule